// File: doc/BRIEF.md
# Two-Way Interleaved Slow Function Unit

This block lets a slow combinational function run at full clock rate by building several copies of it and handing successive inputs to the copies in turn. A small modulo counter decides which copy takes the word on the input in the current cycle. That copy keeps the word in its own holding register until its turn comes round again. While it waits, the other copies take the next inputs. Each copy therefore has several clock periods to settle, and a finished result still leaves the block every cycle. An output multiplexer picks the copy whose result has had the longest time to settle, and an output register captures it.

With COPIES copies the block behaves like a pipeline of COPIES stages. A word presented in one cycle appears at the output COPIES cycles later, and a new result follows every cycle. A valid flag travels beside the data with the same delay. There is no back-pressure and no ready signal. The input is sampled on every clock edge, whether or not the valid flag is set, and the consumer must take every output word in the cycle it is shown. The replicated function is a simple stand-in that the requirements define. COPIES must be 2 or more.

Top module: `ilv_unit`

## Requirements
- R1: A copy selector counts 0, 1, ..., COPIES-1 and then wraps to 0, stepping on every clock edge. Exactly one copy loads the input word on each edge.
- R2: Each copy keeps its captured input unchanged on every edge where it is not selected. The copy being read by the output multiplexer is never the copy being loaded.
- R3: A word X presented at `in_data` before clock edge e appears on `out_data` after edge e+COPIES-1, that is COPIES cycles after it was presented. The value shown is C(X) = ((3*X) xor (X >> 1)) + OFFSET, with every step taken modulo 2^WIDTH. The default OFFSET is 91.
- R4: Inputs may arrive back to back with no gap. One result leaves per clock, so an unbroken run of valid inputs gives an equally long unbroken run of valid outputs.
- R5: `out_valid` equals `in_valid` delayed by exactly COPIES cycles.
- R6: A synchronous reset sets the selector to 0 and clears the held inputs, `out_data` and `out_valid`. For the first COPIES cycles after reset is released, `out_valid` stays low, whatever was driven before or during reset.
- R7: There is no back-pressure. `in_data` is taken on every edge whatever the state of `in_valid`, so `out_data` carries C(X) at the R3 delay even for words presented with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the input word |
| in_data | input | WIDTH | Input word, sampled every cycle |
| out_valid | output | 1 | `in_valid` delayed by COPIES cycles |
| out_data | output | WIDTH | Registered C(in_data), COPIES cycles after the input |

## Verification
A word driven in a given cycle is due at the output exactly COPIES cycles later, and its flag is due in the same cycle. For the first COPIES cycles after reset is released only a low flag is due. The bench keeps a short history of every word and flag it drives, counted from the release of reset. Each sample is taken at a falling edge, before the next word is driven, and is compared with the history entry COPIES cycles back. The expected data is computed arithmetically from the formula in R3. The test walks through all 256 byte values with a broken valid pattern, then a long unbroken random run, then a reset in mid-stream.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned DEF_WIDTH  = 8;
  localparam int unsigned DEF_COPIES = 2;
  localparam int unsigned DEF_OFFSET = 91;
endpackage

// File: rtl/ilv_turn.sv
module ilv_turn #(
  parameter int unsigned COPIES = ilv_pkg::DEF_COPIES,
  localparam int unsigned SW = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SW-1:0]     turn,
  output logic [SW-1:0]     pick,
  output logic [COPIES-1:0] load_vec
);
  localparam logic [SW-1:0] LAST = SW'(COPIES - 1);

  always_ff @(posedge clk) begin
    if (rst) turn <= '0;
    else     turn <= (turn == LAST) ? '0 : turn + 1'b1;
  end

  // the oldest loaded copy is the one that will load next
  assign pick = (turn == LAST) ? '0 : turn + 1'b1;

  for (genvar i = 0; i < COPIES; i++) begin : g_dec
    assign load_vec[i] = (turn == SW'(i));
  end

  assert_turn_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (turn == LAST) |=> (turn == '0));
  assert_turn_range_R1: assert property (@(posedge clk) disable iff (rst)
    turn <= LAST);
  assert_one_load_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(load_vec) == 1);
endmodule

// File: rtl/ilv_copy.sv
module ilv_copy #(
  parameter int unsigned WIDTH  = ilv_pkg::DEF_WIDTH,
  parameter int unsigned OFFSET = ilv_pkg::DEF_OFFSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] held;
  logic [WIDTH-1:0] tripled;

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= x;
  end

  // slow stand-in function, given COPIES-1 cycles to settle
  always_comb begin
    tripled = held + (held << 1);
    result  = (tripled ^ (held >> 1)) + WIDTH'(OFFSET);
  end

  assert_hold_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held));
endmodule

// File: rtl/ilv_vdelay.sv
module ilv_vdelay #(
  parameter int unsigned DEPTH = ilv_pkg::DEF_COPIES,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic vin,
  output logic vout
);
  logic [DEPTH-1:0] stages;
  logic [CW-1:0]    warm;

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= {stages[DEPTH-2:0], vin};
  end

  assign vout = stages[DEPTH-1];

  // edges since reset, saturating; only used by the check below
  always_ff @(posedge clk) begin
    if (rst)                    warm <= '0;
    else if (warm != CW'(DEPTH)) warm <= warm + 1'b1;
  end

  assert_no_stale_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (warm < CW'(DEPTH)) |-> !vout);
endmodule

// File: rtl/ilv_unit.sv
module ilv_unit #(
  parameter int unsigned WIDTH  = ilv_pkg::DEF_WIDTH,
  parameter int unsigned COPIES = ilv_pkg::DEF_COPIES,
  parameter int unsigned OFFSET = ilv_pkg::DEF_OFFSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  localparam int unsigned SW = (COPIES > 1) ? $clog2(COPIES) : 1;

  logic [SW-1:0]     turn;
  logic [SW-1:0]     pick;
  logic [COPIES-1:0] load_vec;
  logic [WIDTH-1:0]  res [COPIES];

  ilv_turn #(.COPIES(COPIES)) u_turn (
    .clk(clk), .rst(rst), .turn(turn), .pick(pick), .load_vec(load_vec)
  );

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    ilv_copy #(.WIDTH(WIDTH), .OFFSET(OFFSET)) u_copy (
      .clk(clk), .rst(rst), .load(load_vec[i]), .x(in_data), .result(res[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_data <= '0;
    else     out_data <= res[pick];
  end

  ilv_vdelay #(.DEPTH(COPIES)) u_vdelay (
    .clk(clk), .rst(rst), .vin(in_valid), .vout(out_valid)
  );

  assert_read_not_load_R2: assert property (@(posedge clk) disable iff (rst)
    pick != turn);
endmodule

// File: tb/tb_ilv_unit.sv
`timescale 1ns/1ps
module tb_ilv_unit;
  localparam int W = 8;
  localparam int N = 2;
  localparam int OFS = 91;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int m = 0;
  int streak = 0;
  int best = 0;
  logic         hv [64];
  logic [W-1:0] hd [64];

  ilv_unit #(.WIDTH(W), .COPIES(N), .OFFSET(OFS)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] cref(input logic [W-1:0] x);
    int v;
    v = (((3 * x) % 256) ^ (x / 2)) + OFS;
    return W'(v % 256);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (m=%0d)", tag, act, exp, m);
    end
  endtask

  task automatic cyc(input logic v, input logic [W-1:0] d);
    @(negedge clk);
    if (m >= N) begin
      // R3 R7 (and R1 R2 by the right copy result): data due N cycles later
      chk(out_data == cref(hd[(m-N)%64]), "R3", int'(out_data), int'(cref(hd[(m-N)%64])));
      chk(out_valid == hv[(m-N)%64], "R5", int'(out_valid), int'(hv[(m-N)%64]));
    end else begin
      chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
    end
    if (out_valid) begin streak++; if (streak > best) best = streak; end
    else streak = 0;
    in_valid = v; in_data = d;
    hv[m%64] = v; hd[m%64] = d;
    m++;
  endtask

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hA5;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
      chk(out_data == '0, "R6", int'(out_data), 0);
    end
    rst = 1'b0;
    in_valid = 1'b0;
    m = 0;
    streak = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(3);
    // R7 R5: full sweep of byte values, valid low on every third word
    for (int i = 0; i < 256; i++) cyc(logic'((i % 3) != 0), W'(i));
    // R4: unbroken run of valid random words
    best = 0; streak = 0;
    for (int i = 0; i < 300; i++) cyc(1'b1, W'($urandom_range(0, 255)));
    for (int i = 0; i < N; i++) cyc(1'b0, W'(i));
    chk(best >= 300, "R4", best, 300);
    // R6: reset in mid-stream with valid words in flight
    for (int i = 0; i < 5; i++) cyc(1'b1, W'(200 + i));
    do_reset(2);
    for (int i = 0; i < 40; i++) cyc(logic'(i % 2), W'($urandom_range(0, 255)));
    for (int i = 0; i < N; i++) cyc(1'b0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule